// File: doc/BRIEF.md
# Watchdog Timer with Unlock-Guarded Restart

The block is a free-running watchdog. A counter advances on every clock and has to be restarted by software before it reaches its timeout. A restart is a protected write to a control register. That write is accepted only when it closely follows a two-write unlock sequence sent to a dedicated unlock address. This guards the restart against stray writes.

When the counter reaches its timeout, three things happen:
- a sticky timeout flag is set in the status register;
- the counter starts over from zero;
- a one-cycle CPU reset request is issued, but only if the reset-enable input is high.

For a fixed hold period after a timeout, the flag cannot be cleared. A read of the status register is the only action that clears the flag, and only once the hold has ended. An accepted restart also ends the hold at once. The external reset clears all of the state.

Top module: `wdt_guard`

## Requirements
- R1: While `rst_n` is low, `rst_req` is 0 and the status flag reads 0. Counting starts again when `rst_n` is released, so the first timeout falls on the TIMEOUT-th rising edge after release.
- R2: Without a restart, a timeout occurs on every TIMEOUT-th rising edge. The counter restarts from zero after each timeout.
- R3: A timeout sets the flag, which is bit 0 of the status register at address STAT_ADDR. This happens whether or not `rst_en` is high.
- R4: `rst_req` goes high for exactly one cycle, in the cycle after a timeout edge. It does so only when `rst_en` was high at that edge.
- R5: A read strobe to STAT_ADDR clears the flag at that edge, once the hold has ended. `rdata` shows the flag value from before the clear. Writes to STAT_ADDR do not clear the flag.
- R6: For the HOLD rising edges that follow a timeout edge, status reads leave the flag at 1. A read on the next edge after that window clears it.
- R7: The unlock sequence is two writes to TA_ADDR, 0xAA and then 0x55. If the next write goes to CTRL_ADDR with bit 0 set, it restarts the counter, and the next timeout follows TIMEOUT edges later.
- R8: An accepted restart ends the hold at once, so the next status read clears the flag.
- R9: A CTRL_ADDR write is ignored if it is not preceded by a valid unlock. A TA_ADDR write with a wrong value in the sequence cancels a partial unlock.
- R10: The protected write must land within UNLOCK_WIN rising edges after the 0x55 edge. Any later write is ignored.
- R11: CTRL_ADDR reads as 0, because the restart bit clears itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | External reset, active low |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read data, combinational from `addr` |
| rst_en | input | 1 | Enables the reset request on timeout |
| rst_req | output | 1 | One-cycle CPU reset request |

## Verification
Two results can be observed directly at the ports:
- `rst_req` rises in the cycle after the timeout edge. The bench therefore expects the pulse at the negedge whose edge count equals the restart or release edge plus TIMEOUT.
- `rdata` is combinational, so a read returns the flag in the same cycle.

The flag clear caused by a read takes effect at that read's edge and is seen only by the next read. The hold and unlock-window boundaries are therefore probed by reads and writes placed on exact edge offsets: HOLD and HOLD+1 for the hold, and UNLOCK_WIN and UNLOCK_WIN+1 for the unlock window. Every input is driven at a negedge and sampled one time unit later, so each write or read lands on one known rising edge.

// File: rtl/wdt_guard.sv
module wdt_guard #(
  parameter int TIMEOUT    = 122880,
  parameter int HOLD       = 8192,
  parameter int UNLOCK_WIN = 4,
  parameter logic [7:0] TA_ADDR   = 8'h30,
  parameter logic [7:0] STAT_ADDR = 8'h10,
  parameter logic [7:0] CTRL_ADDR = 8'h20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  input  logic       wr_en,
  input  logic       rd_en,
  output logic [7:0] rdata,
  input  logic       rst_en,
  output logic       rst_req
);
  localparam int CW = $clog2(TIMEOUT);
  localparam int HW = $clog2(HOLD + 1);
  localparam int WW = $clog2(UNLOCK_WIN + 1);

  logic [CW-1:0] cnt;
  logic [HW-1:0] hold;
  logic [WW-1:0] win;
  logic          armed, flag;

  wire ta_wr   = wr_en && addr == TA_ADDR;
  wire restart = wr_en && addr == CTRL_ADDR && win != '0 && wdata[0];
  wire expire  = !restart && cnt == CW'(TIMEOUT - 1);
  wire clr     = rd_en && addr == STAT_ADDR && hold == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      win   <= '0;
    end else begin
      if (win != '0) win <= win - 1'b1;
      if (wr_en) begin
        armed <= ta_wr && wdata == 8'hAA;
        win   <= (armed && ta_wr && wdata == 8'h55) ? WW'(UNLOCK_WIN) : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      hold    <= '0;
      flag    <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      cnt     <= (restart || expire) ? '0 : cnt + 1'b1;
      rst_req <= expire && rst_en;
      if (restart)          hold <= '0;
      else if (expire)      hold <= HW'(HOLD);
      else if (hold != '0)  hold <= hold - 1'b1;
      if (expire)   flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end

  assign rdata = (addr == STAT_ADDR) ? {7'b0, flag} : 8'h00;

  // R4
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  // R4
  pulse_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(rst_en));
  // R3
  pulse_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> flag);
  // R6
  hold_keeps_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold != '0 |=> flag);
  // R5
  clear_by_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(rd_en && addr == STAT_ADDR));
  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(TIMEOUT));
  // R10
  window_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win <= WW'(UNLOCK_WIN));
endmodule

// File: tb/sim_wdt_guard.sv
module sim_wdt_guard;
  localparam int CLK_PERIOD = 10;
  localparam int TO = 200, HO = 40, WIN = 4;
  localparam logic [7:0] TA = 8'h30, ST = 8'h10, CT = 8'h20;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, rst_en = 1;
  logic [7:0] addr = 0, wdata = 0, rdata;
  logic rst_req;
  int cyc = 0, pulses = 0, tests = 0, fails = 0;

  wdt_guard #(.TIMEOUT(TO), .HOLD(HO), .UNLOCK_WIN(WIN),
              .TA_ADDR(TA), .STAT_ADDR(ST), .CTRL_ADDR(CT)) u0 (
    .clk, .rst_n, .addr, .wdata, .wr_en, .rd_en, .rdata, .rst_en, .rst_req);

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_req) pulses <= pulses + 1;

  function automatic int due(input int edge_at);
    return edge_at + TO;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, output int e);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk); e = cyc; wr_en = 0; addr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    addr = a; rd_en = 1; #1 v = rdata;
    @(negedge clk); rd_en = 0; addr = 0;
  endtask

  task automatic restart(output int e);
    int x;
    wr(TA, 8'hAA, x); wr(TA, 8'h55, x); wr(CT, 8'h01, e);
  endtask

  task automatic wait_pulse(output int at);
    at = -1;
    for (int i = 0; i < 3 * TO; i++) begin
      @(negedge clk);
      if (rst_req) begin at = cyc; break; end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int rel, t, e, x, p0, gap;
    logic [7:0] v;
    void'($urandom(7));
    idle(4);
    chk(rst_req == 0, "R1 reset req", rst_req, 0);
    rd(ST, v); chk(v == 0, "R1 reset flag", v, 0);
    rst_n = 1; rel = cyc;
    wait_pulse(t); chk(t == due(rel), "R1/R2 first timeout", t, due(rel));
    idle(1); chk(rst_req == 0, "R4 single pulse", rst_req, 0);
    rd(ST, v); chk(v == 1, "R3 flag set", v, 1);
    idle(HO - 3);
    rd(ST, v); chk(v == 1, "R6 hold last edge", v, 1);
    rd(ST, v); chk(v == 1, "R6 first clearing read", v, 1);
    rd(ST, v); chk(v == 0, "R5/R6 cleared after hold", v, 0);
    wait_pulse(x); chk(x == t + TO, "R2 periodic timeout", x, t + TO);
    idle(HO + 2);
    wr(ST, 8'h00, e); rd(ST, v); chk(v == 1, "R5 write no clear", v, 1);
    rd(ST, v); chk(v == 0, "R5 read clears", v, 0);
    t = x; rst_en = 0; p0 = pulses;
    idle(t + TO + 3 - cyc);
    chk(pulses == p0, "R4 no pulse when disabled", pulses - p0, 0);
    rd(ST, v); chk(v == 1, "R3 flag without enable", v, 1);
    rst_en = 1;
    restart(e); wait_pulse(t); chk(t == due(e), "R7 restart timing", t, due(e));
    rd(ST, v);
    restart(e);
    rd(ST, v); chk(v == 1, "R8 flag before clear", v, 1);
    rd(ST, v); chk(v == 0, "R8 restart ends hold", v, 0);
    wr(CT, 8'h01, x);
    wr(TA, 8'hAA, x); wr(TA, 8'h12, x); wr(TA, 8'h55, x); wr(CT, 8'h01, x);
    wait_pulse(t); chk(t == due(e), "R9 unguarded restart ignored", t, due(e));
    wr(TA, 8'hAA, x); wr(TA, 8'h55, x); idle(WIN - 1); wr(CT, 8'h01, e);
    rd(CT, v); chk(v == 0, "R11 ctrl reads zero", v, 0);
    wr(TA, 8'hAA, x); wr(TA, 8'h55, x); idle(WIN); wr(CT, 8'h01, x);
    wait_pulse(t); chk(t == due(e), "R10 window edge and late write", t, due(e));
    idle(20); rst_n = 0; idle(3);
    rd(ST, v); chk(v == 0, "R1 reset clears flag", v, 0);
    rst_n = 1; rel = cyc;
    wait_pulse(t); chk(t == due(rel), "R1 recount after reset", t, due(rel));
    idle(HO + 2); rd(ST, v);
    p0 = pulses;
    for (int i = 0; i < 15; i++) begin
      gap = $urandom_range(TO - 20, 0);
      rst_en = $urandom_range(1, 0);
      idle(gap); restart(e);
    end
    chk(pulses == p0, "R7 random restarts prevent timeout", pulses - p0, 0);
    rd(ST, v); chk(v == 0, "R7 no flag under restarts", v, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule